// File: doc/BRIEF.md
# Multiplexed Bus Target Bridge

This block is the device end of a narrow, multiplexed parallel bus. The master never drives a full address. It places the low byte on the shared eight-bit data lines and pulses a low-address latch strobe. It then places the high byte and pulses a high-address latch strobe. Both target instances on the bus latch the address. Only the instance whose active-low chip select the master pulls low answers the following read or write strobe.

A selected write commits the data byte to an internal register/memory port at the latched address. A selected read captures the byte that the port returns and drives it back through a separate output and an output-enable line. The output-enable line controls the pad-level tristate of the shared bus. Every access ends with an active-low acknowledge, raised after a configurable access delay. The acknowledge stays low for as long as the master holds its strobe and select, and is withdrawn once either one returns high.

All bus inputs cross into the target clock through a synchronising flip-flop chain before any edge is detected. The data lines pass through the same chain, so a byte and the strobe that qualifies it arrive together.

Top module: `mbt_target`

## Requirements
- R1: A rising edge of `alat_lo` (after synchronisation) loads the byte on `bus_din` into address bits 7:0, seen on `mem_addr[7:0]`; chip select is not required.
- R2: A rising edge of `alat_hi` (after synchronisation) loads the byte on `bus_din` into address bits 15:8, seen on `mem_addr[15:8]`; chip select is not required.
- R3: A falling `rd_n` or `wr_n` while `cs_n` is high is ignored: no `mem_we` pulse, `ack_n` stays 1, `bus_doe` stays 0, and the port contents are unchanged.
- R4: A falling `wr_n` with `cs_n` low gives exactly one `mem_we` cycle, carrying the current `bus_din` byte on `mem_wdata` and the latched address on `mem_addr`.
- R5: A falling `rd_n` with `cs_n` low makes `bus_dout` carry the `mem_rdata` byte of the latched address from the cycle `ack_n` falls until it rises.
- R6: `ack_n` goes low ACCESS_DELAY cycles after the strobe edge is detected, that is SYNC_STAGES+ACCESS_DELAY+1 observed cycles after the pin falls. It stays low while the strobe and `cs_n` remain low.
- R7: `ack_n` returns to 1 and `bus_doe` to 0 SYNC_STAGES+1 cycles after the strobe or `cs_n` pin goes high. A strobe or select that is released before the acknowledge cancels the access with no acknowledge.
- R8: `bus_doe` is 1 only while a read is acknowledged, never during a write.
- R9: After reset `ack_n` is 1, `bus_doe` is 0, `mem_we` is 0 and `mem_addr` is 0. When a read and a write strobe fall in the same cycle, the read is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_din | input | DATA_W | Shared data lines as seen by the target |
| bus_dout | output | DATA_W | Byte driven onto the data lines during a read |
| bus_doe | output | 1 | Output enable for bus_dout, high drives the pads |
| cs_n | input | 1 | Active-low select of this instance |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| alat_lo | input | 1 | Low address byte latch strobe, active high |
| alat_hi | input | 1 | High address byte latch strobe, active high |
| ack_n | output | 1 | Active-low access acknowledge |
| mem_addr | output | ADDR_W | Latched address to the internal port |
| mem_wdata | output | DATA_W | Write byte to the internal port |
| mem_we | output | 1 | Single-cycle write enable to the internal port |
| mem_rdata | input | DATA_W | Read byte from the internal port at mem_addr |

## Verification
On every cycle the assertions check the following. The acknowledge and the write enable only follow a selected strobe. The output enable only accompanies an acknowledged read. A write enable lasts one cycle. The acknowledge drops out the cycle after the synchronised select goes high. The bench's scenarios are needed for the rest: the exact acknowledge latency, address assembly from two latch events, read-after-write data integrity, the cancelled read, and an unselected write leaving the memory untouched. The bench runs a behavioural model against every cycle, and these scenarios also carry directed checks.

// File: rtl/mbt_pkg.sv
package mbt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_ACK  = 2'd2
   } mbt_state_e;

   localparam int CTRL_BITS = 5;  // cs_n, rd_n, wr_n, alat_lo, alat_hi
   localparam logic [CTRL_BITS-1:0] CTRL_IDLE = 5'b00111;
endpackage

// File: rtl/mbt_sync.sv
module mbt_sync #(
   parameter int WIDTH = 8,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mbt_edge.sv
module mbt_edge #(
   parameter int WIDTH = 2,
   parameter bit FALLING = 1'b0,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] sig_i,
   output logic [WIDTH-1:0] edge_o
);
   logic [WIDTH-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= RST_VAL;
      else        prev <= sig_i;
   end

   generate
      if (FALLING) begin : g_fall
         assign edge_o = prev & ~sig_i;
      end else begin : g_rise
         assign edge_o = ~prev & sig_i;
      end
   endgenerate
endmodule

// File: rtl/mbt_addr_latch.sv
module mbt_addr_latch #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lo_rise_i,
   input  logic              hi_rise_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int HI_LSB = ADDR_W - DATA_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o <= '0;
      end else begin
         if (lo_rise_i) addr_o[DATA_W-1:0]     <= data_i;
         if (hi_rise_i) addr_o[ADDR_W-1:HI_LSB] <= data_i;
      end
   end
endmodule

// File: rtl/mbt_access_ctl.sv
module mbt_access_ctl
   import mbt_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ACCESS_DELAY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n_i,
   input  logic              rd_n_i,
   input  logic              wr_n_i,
   input  logic              rd_fall_i,
   input  logic              wr_fall_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              we_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic              ack_n_o,
   output logic              doe_o,
   output logic [DATA_W-1:0] dout_o
);
   localparam int CNT_W = $clog2(ACCESS_DELAY + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACCESS_DELAY - 1);

   mbt_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             is_read;
   logic             released;
   logic             start;

   assign start    = !cs_n_i && (rd_fall_i || wr_fall_i);
   assign released = cs_n_i || (is_read ? rd_n_i : wr_n_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         is_read <= 1'b0;
         we_o    <= 1'b0;
         wdata_o <= '0;
         dout_o  <= '0;
      end else begin
         we_o <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state   <= ST_WAIT;
                  cnt     <= CNT_LOAD;
                  is_read <= rd_fall_i;
                  if (!rd_fall_i) begin
                     we_o    <= 1'b1;
                     wdata_o <= data_i;
                  end
               end
            end
            ST_WAIT: begin
               if (released) begin
                  state <= ST_IDLE;
               end else if (cnt == '0) begin
                  state <= ST_ACK;
                  if (is_read) dout_o <= rdata_i;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_ACK: begin
               if (released) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign ack_n_o = (state != ST_ACK);
   assign doe_o   = (state == ST_ACK) && is_read;
endmodule

// File: rtl/mbt_target.sv
module mbt_target
   import mbt_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16,
   parameter int SYNC_STAGES = 2,
   parameter int ACCESS_DELAY = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              alat_lo,
   input  logic              alat_hi,
   output logic              ack_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int SW = DATA_W + CTRL_BITS;
   localparam logic [SW-1:0] SYNC_RST = {{DATA_W{1'b0}}, CTRL_IDLE};

   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("mbt_target: ADDR_W must be twice DATA_W");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mbt_target: SYNC_STAGES must be at least 2");
      end
      if (ACCESS_DELAY < 1) begin : g_bad_delay
         $error("mbt_target: ACCESS_DELAY must be at least 1");
      end
   endgenerate

   logic [SW-1:0]     raw_bus;
   logic [SW-1:0]     sync_bus;
   logic              cs_s_n, rd_s_n, wr_s_n, lo_s, hi_s;
   logic [DATA_W-1:0] data_s;
   logic [1:0]        lat_rise;
   logic [1:0]        stb_fall;

   assign raw_bus = {bus_din, alat_hi, alat_lo, wr_n, rd_n, cs_n};

   mbt_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) i_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_bus), .q_o(sync_bus)
   );

   assign cs_s_n = sync_bus[0];
   assign rd_s_n = sync_bus[1];
   assign wr_s_n = sync_bus[2];
   assign lo_s   = sync_bus[3];
   assign hi_s   = sync_bus[4];
   assign data_s = sync_bus[SW-1:CTRL_BITS];

   mbt_edge #(.WIDTH(2), .FALLING(1'b0), .RST_VAL(2'b00)) i_lat_edge (
      .clk(clk), .rst_n(rst_n), .sig_i({hi_s, lo_s}), .edge_o(lat_rise)
   );

   mbt_edge #(.WIDTH(2), .FALLING(1'b1), .RST_VAL(2'b11)) i_stb_edge (
      .clk(clk), .rst_n(rst_n), .sig_i({wr_s_n, rd_s_n}), .edge_o(stb_fall)
   );

   mbt_addr_latch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_addr (
      .clk(clk), .rst_n(rst_n),
      .lo_rise_i(lat_rise[0]), .hi_rise_i(lat_rise[1]),
      .data_i(data_s), .addr_o(mem_addr)
   );

   mbt_access_ctl #(.DATA_W(DATA_W), .ACCESS_DELAY(ACCESS_DELAY)) i_ctl (
      .clk(clk), .rst_n(rst_n),
      .cs_n_i(cs_s_n), .rd_n_i(rd_s_n), .wr_n_i(wr_s_n),
      .rd_fall_i(stb_fall[0]), .wr_fall_i(stb_fall[1]),
      .data_i(data_s), .rdata_i(mem_rdata),
      .we_o(mem_we), .wdata_o(mem_wdata),
      .ack_n_o(ack_n), .doe_o(bus_doe), .dout_o(bus_dout)
   );
endmodule

// File: rtl/mbt_target_chk.sv
module mbt_target_chk (
   input logic clk,
   input logic rst_n,
   input logic ack_n,
   input logic bus_doe,
   input logic mem_we,
   input logic cs_s_n,
   input logic rd_s_n,
   input logic wr_s_n
);
   // R3: an acknowledge only follows a selected access
   assert_ack_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |-> !$past(cs_s_n));

   // R3: a write enable only follows a selected strobe
   assert_we_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !$past(cs_s_n));

   // R4: the write enable lasts exactly one cycle
   assert_we_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

   // R6: the acknowledge is held only while a strobe is held
   assert_ack_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_n |-> (!$past(rd_s_n) || !$past(wr_s_n)));

   // R7: deselect withdraws the acknowledge on the next cycle
   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_n && cs_s_n) |=> ack_n);

   // R8: data drive only during an acknowledged read
   assert_doe_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_doe |-> (!ack_n && !$past(rd_s_n)));
endmodule

bind mbt_target mbt_target_chk i_chk (
   .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .bus_doe(bus_doe),
   .mem_we(mem_we), .cs_s_n(cs_s_n), .rd_s_n(rd_s_n), .wr_s_n(wr_s_n)
);

// File: tb/test_mbt_target.sv
`timescale 1ns/1ps
module test_mbt_target;
   localparam int S = 2;
   localparam int D = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_din = 8'h00;
   logic [7:0]  bus_dout;
   logic        bus_doe;
   logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
   logic        alat_lo = 1'b0, alat_hi = 1'b0;
   logic        ack_n;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic        mem_we;
   logic [7:0]  mem_rdata = 8'h00;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   mbt_target #(.DATA_W(8), .ADDR_W(16), .SYNC_STAGES(S), .ACCESS_DELAY(D)) i_mbt_target (
      .clk(clk), .rst_n(rst_n), .bus_din(bus_din), .bus_dout(bus_dout),
      .bus_doe(bus_doe), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .alat_lo(alat_lo), .alat_hi(alat_hi), .ack_n(ack_n),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
      .mem_rdata(mem_rdata)
   );

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] dflt(logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   // port-side memory, written from the design's write port
   logic [7:0] port_mem [int];
   // model memory, written from the model's own decisions
   logic [7:0] model_mem [int];

   // behavioural reference model
   logic [12:0] pipe [S];
   logic        p_rd, p_wr, p_lo, p_hi;
   int          mst, mcnt;
   bit          mread, m_we;
   logic [7:0]  m_wd, m_dout;
   logic [15:0] m_addr;

   always @(posedge clk) begin
      logic [12:0] cur;
      logic c_cs, c_rd, c_wr, c_lo, c_hi, stb;
      logic [7:0] c_d;
      bit rdf, wrf;
      if (rst_n && mem_we) port_mem[int'(mem_addr)] = mem_wdata;
      if (!rst_n) begin
         for (int i = 0; i < S; i++) pipe[i] = 13'b00111;
         p_rd = 1; p_wr = 1; p_lo = 0; p_hi = 0;
         mst = 0; mcnt = 0; mread = 0; m_we = 0;
         m_wd = 0; m_dout = 0; m_addr = 0;
      end else begin
         cur = pipe[S-1];
         c_cs = cur[0]; c_rd = cur[1]; c_wr = cur[2];
         c_lo = cur[3]; c_hi = cur[4]; c_d = cur[12:5];
         m_we = 0;
         if (c_lo && !p_lo) m_addr[7:0]  = c_d;
         if (c_hi && !p_hi) m_addr[15:8] = c_d;
         rdf = p_rd && !c_rd;
         wrf = p_wr && !c_wr;
         stb = mread ? c_rd : c_wr;
         if (mst == 0) begin
            if (!c_cs && (rdf || wrf)) begin
               mst = 1; mcnt = D - 1; mread = rdf;
               if (!rdf) begin
                  m_we = 1; m_wd = c_d; model_mem[int'(m_addr)] = c_d;
               end
            end
         end else if (mst == 1) begin
            if (c_cs || stb) mst = 0;
            else if (mcnt == 0) begin
               mst = 2;
               if (mread) m_dout = model_mem.exists(int'(m_addr)) ?
                                   model_mem[int'(m_addr)] : dflt(m_addr);
            end else mcnt--;
         end else begin
            if (c_cs || stb) mst = 0;
         end
         p_rd = c_rd; p_wr = c_wr; p_lo = c_lo; p_hi = c_hi;
         for (int i = S - 1; i > 0; i--) pipe[i] = pipe[i-1];
         pipe[0] = {bus_din, alat_hi, alat_lo, wr_n, rd_n, cs_n};
      end
   end

   // per-cycle comparison and port read data
   always @(negedge clk) begin
      mem_rdata <= port_mem.exists(int'(mem_addr)) ? port_mem[int'(mem_addr)] : dflt(mem_addr);
      if (rst_n && !done) begin
         chk(ack_n == (mst != 2), "R6", "ack_n vs model", ack_n, mst != 2);
         chk(bus_doe == (mst == 2 && mread), "R8", "bus_doe vs model", bus_doe, mst == 2 && mread);
         if (bus_doe) chk(bus_dout == m_dout, "R5", "bus_dout vs model", bus_dout, m_dout);
         chk(mem_we == m_we, "R4", "mem_we vs model", mem_we, m_we);
         if (mem_we) chk(mem_wdata == m_wd, "R4", "mem_wdata vs model", mem_wdata, m_wd);
         chk(mem_addr == m_addr, "R1", "mem_addr vs model", mem_addr, m_addr);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_addr(logic [15:0] a);
      @(negedge clk); bus_din = a[7:0]; alat_lo = 1;
      cyc(3); alat_lo = 0;
      cyc(2); bus_din = a[15:8]; alat_hi = 1;
      cyc(3); alat_hi = 0;
      cyc(3);
   endtask

   // one strobe access; is_rd picks the strobe
   task automatic access(bit sel, bit is_rd, logic [7:0] wdata,
                         output bit acked, output int lat, output int rel,
                         output logic [7:0] rdata, output bit held);
      acked = 0; lat = 0; rel = 0; rdata = 0; held = 0;
      @(negedge clk); bus_din = wdata; cs_n = !sel;
      @(negedge clk);
      if (is_rd) rd_n = 0; else wr_n = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk); lat++;
         if (!ack_n) begin acked = 1; break; end
      end
      if (acked) begin
         rdata = bus_dout;
         cyc(3);
         held = !ack_n;
      end
      rd_n = 1; wr_n = 1;
      if (acked) begin
         for (int i = 0; i < 10; i++) begin
            @(negedge clk); rel++;
            if (ack_n) break;
         end
      end
      cs_n = 1;
      cyc(4);
   endtask

   initial begin
      bit acked, held;
      int lat, rel;
      logic [7:0] rd;

      cyc(3);
      // R9: reset state
      chk(ack_n === 1'b1, "R9", "reset ack_n", ack_n, 1);
      chk(bus_doe === 1'b0, "R9", "reset bus_doe", bus_doe, 0);
      chk(mem_we === 1'b0, "R9", "reset mem_we", mem_we, 0);
      chk(mem_addr === 16'h0, "R9", "reset mem_addr", mem_addr, 0);
      rst_n = 1;
      cyc(2);

      // R1, R2: two latch events assemble the address without select
      set_addr(16'h12A5);
      chk(mem_addr == 16'h12A5, "R1", "address after latches", mem_addr, 16'h12A5);
      set_addr(16'h12C3);
      chk(mem_addr[15:8] == 8'h12, "R2", "high byte kept", mem_addr[15:8], 8'h12);
      chk(mem_addr[7:0] == 8'hC3, "R1", "low byte replaced", mem_addr[7:0], 8'hC3);

      // R4, R6, R7: selected write
      access(1, 0, 8'h3C, acked, lat, rel, rd, held);
      chk(acked, "R4", "write acknowledged", acked, 1);
      chk(lat == S + D + 1, "R6", "write ack latency", lat, S + D + 1);
      chk(held, "R6", "ack held with strobe", held, 1);
      chk(rel == S + 1, "R7", "write release latency", rel, S + 1);

      // R5: read back
      access(1, 1, 8'h00, acked, lat, rel, rd, held);
      chk(acked, "R5", "read acknowledged", acked, 1);
      chk(rd == 8'h3C, "R5", "read after write", rd, 8'h3C);
      chk(lat == S + D + 1, "R6", "read ack latency", lat, S + D + 1);
      chk(rel == S + 1, "R7", "read release latency", rel, S + 1);

      // R3: unselected write ignored, memory unchanged
      set_addr(16'hF00F);
      access(0, 0, 8'h99, acked, lat, rel, rd, held);
      chk(!acked, "R3", "no ack when unselected", acked, 0);
      access(1, 1, 8'h00, acked, lat, rel, rd, held);
      chk(rd == dflt(16'hF00F), "R3", "unselected write left memory", rd, dflt(16'hF00F));

      // R3: unselected read gives no drive
      access(0, 1, 8'h00, acked, lat, rel, rd, held);
      chk(!acked && !bus_doe, "R3", "unselected read silent", acked, 0);

      // R7: read cancelled before the acknowledge
      @(negedge clk); cs_n = 0;
      @(negedge clk); rd_n = 0;
      @(negedge clk); rd_n = 1;
      acked = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (!ack_n || bus_doe) acked = 1;
      end
      cs_n = 1;
      chk(!acked, "R7", "cancelled read has no ack", acked, 0);
      cyc(3);

      // R9: read and write fall together, read wins
      set_addr(16'h0777);
      @(negedge clk); bus_din = 8'hEE; cs_n = 0;
      @(negedge clk); rd_n = 0; wr_n = 0;
      cyc(S + D + 1);
      chk(!bus_doe == 1'b0, "R9", "simultaneous strobes read", bus_doe, 1);
      chk(bus_dout == dflt(16'h0777), "R9", "simultaneous read data", bus_dout, dflt(16'h0777));
      rd_n = 1; wr_n = 1; cs_n = 1;
      cyc(6);

      // R4, R5: second location, deselect releases (R7)
      set_addr(16'hBEEF);
      access(1, 0, 8'h5E, acked, lat, rel, rd, held);
      access(1, 1, 8'h00, acked, lat, rel, rd, held);
      chk(rd == 8'h5E, "R5", "second location read", rd, 8'h5E);
      set_addr(16'h12C3);
      access(1, 1, 8'h00, acked, lat, rel, rd, held);
      chk(rd == 8'h3C, "R4", "first location kept", rd, 8'h3C);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule